// File: doc/BRIEF.md
# Line-Delay Polyphase Combiner

This block merges the two polyphase partial-sum streams of one dimension of a non-separable subband filter into one partial sum for the next outer dimension. Every accepted sample carries an even-phase value and an odd-phase value. Each phase feeds a chain of line buffers. A line is the row length of the current decomposition level. The delayed copies are scaled by signed fixed-point ratio coefficients and added to the undelayed pair. The leading tap of each phase has unit weight, because that weight was already applied upstream.

The filter length `K` sets the tap counts. The even phase has `(K+1)/2` taps, which use `(K+1)/2 - 1` line buffers. The odd phase has `K/2` taps, which use `K/2 - 1` line buffers. Together the two phases store `K-2` lines. All buffers share one read/write pointer that wraps at the programmed line length, so a single buffer of `MAX_LEN` entries serves every level. The line length is loaded with a load pulse before a stream starts. The output is flagged valid only once enough whole lines have been accepted to fill the deepest tap.

`K` must be at least 4. With the default `K = 5`, there are two even ratios (one line and two lines back) and one odd ratio (one line back).

Top module: `line_poly_combiner`

## Requirements
- R1: After reset, `out_valid_o` is 0, `out_o` is 0 and the line length is `MAX_LEN`.
- R2: The undelayed even and odd inputs of an accepted sample always enter the sum with weight exactly 1.
- R3: Even tap i (1 ≤ i < (K+1)/2) adds `coef_even_i[(i-1)*COEF_W +: COEF_W]` times the even input accepted i lines earlier.
- R4: Odd tap i (1 ≤ i < K/2) adds `coef_odd_i[(i-1)*COEF_W +: COEF_W]` times the odd input accepted i lines earlier.
- R5: Coefficients are two's-complement with `FRAC_W` fraction bits. The sum is formed exactly, as (ph0+ph1)·2^FRAC_W plus all products, and is then shifted right arithmetically by `FRAC_W`, which rounds toward minus infinity.
- R6: A line delay counts accepted samples (`in_valid_i` high, `load_i` low), not clocks. Idle cycles do not move the delay.
- R7: A cycle with `load_i` high latches `len_i` as the line length and restarts the pointer and the history. A length of 0 or above `MAX_LEN` is replaced by `MAX_LEN`. A sample offered in the load cycle is ignored.
- R8: A tap that reaches back to before the most recent load or reset contributes zero.
- R9: `out_valid_o` is 1 in the cycle after an accepted sample exactly when at least `(K+1)/2 - 1` whole lines had been accepted since the last load before that sample. Otherwise it is 0.
- R10: `out_o` takes the new sum one cycle after an accepted sample and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Latch line length and restart history |
| len_i | input | LEN_W | Line length in samples (1..MAX_LEN) |
| coef_even_i | input | ((K+1)/2-1)*COEF_W | Even-phase ratio coefficients, tap 1 in the low slice |
| coef_odd_i | input | (K/2-1)*COEF_W | Odd-phase ratio coefficients, tap 1 in the low slice |
| in_valid_i | input | 1 | Sample present on both phase inputs |
| ph0_i | input | DATA_W | Even-phase partial sum, signed |
| ph1_i | input | DATA_W | Odd-phase partial sum, signed |
| out_valid_o | output | 1 | Output sum has full history |
| out_o | output | OUT_W | Combined partial sum, signed |

## Verification
With all ratios zero, the output shows whether the two undelayed terms pass at unit weight. Driving only the even phase, and then only the odd phase, with the other ratios zero separates the taps of each chain and their line offsets. Mixed negative and fractional ratios expose errors in rounding and sign extension. Streams broken by random idle cycles, a line length of 1, an out-of-range length and a reload in the middle of a stream tell delays counted in samples from delays counted in clocks, and show whether the history is cleared and the valid flag delayed to the right line.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    // number of taps on the even phase (includes the unit tap)
    function automatic int taps_even(input int k);
        return (k + 1) / 2;
    endfunction

    // number of taps on the odd phase (includes the unit tap)
    function automatic int taps_odd(input int k);
        return k / 2;
    endfunction
endpackage

// File: rtl/lpc_line_buf.sv
// One line of storage: written and read at a shared circular address.
module lpc_line_buf #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // read returns the value stored one full line ago at this address
    assign rdata_o = mem_q[addr_i];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/lpc_ctrl.sv
// Line pointer, line length register and history fill counter.
module lpc_ctrl #(
    parameter int MAX_LEN = 64,
    parameter int MAXD    = 2,
    parameter int AW      = $clog2(MAX_LEN),
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int FILL_W  = $clog2(MAXD + 1) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              in_valid_i,
    output logic [AW-1:0]     ptr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [FILL_W-1:0] fill_o
);
    typedef struct packed {
        logic [AW-1:0]     ptr;
        logic [LEN_W-1:0]  len;
        logic [FILL_W-1:0] fill;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            if (len_i == '0 || len_i > LEN_W'(MAX_LEN)) begin
                st_d.len = LEN_W'(MAX_LEN);
            end else begin
                st_d.len = len_i;
            end
            st_d.ptr  = '0;
            st_d.fill = '0;
        end else if (in_valid_i) begin
            if ({1'b0, st_q.ptr} == (LEN_W + 1)'(st_q.len) - 1'b1) begin
                st_d.ptr = '0;
                if (st_q.fill < FILL_W'(MAXD)) begin
                    st_d.fill = st_q.fill + 1'b1;
                end
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.ptr  <= '0;
            st_q.len  <= LEN_W'(MAX_LEN);
            st_q.fill <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o  = st_q.ptr;
    assign len_o  = st_q.len;
    assign fill_o = st_q.fill;
endmodule

// File: rtl/lpc_tap_sum.sv
// Weighted sum of the current pair and the line-delayed copies.
module lpc_tap_sum #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    parameter int NE     = 3,
    parameter int NO     = 2,
    parameter int ACC_W  = 36,
    parameter int FILL_W = 3
) (
    input  logic [DATA_W-1:0]          ph0_i,
    input  logic [DATA_W-1:0]          ph1_i,
    input  logic [(NE-1)*DATA_W-1:0]   dly_even_i,
    input  logic [(NO-1)*DATA_W-1:0]   dly_odd_i,
    input  logic [(NE-1)*COEF_W-1:0]   coef_even_i,
    input  logic [(NO-1)*COEF_W-1:0]   coef_odd_i,
    input  logic [FILL_W-1:0]          fill_i,
    output logic signed [ACC_W-1:0]    acc_o
);
    localparam int PW = DATA_W + COEF_W;

    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] sum_even;
    logic signed [ACC_W-1:0] sum_odd;

    always_comb begin
        base = (ACC_W'($signed(ph0_i)) + ACC_W'($signed(ph1_i))) <<< FRAC_W;
    end

    always_comb begin
        logic signed [PW-1:0] prod;
        sum_even = '0;
        for (int i = 1; i < NE; i++) begin
            prod = $signed(dly_even_i[(i-1)*DATA_W +: DATA_W])
                 * $signed(coef_even_i[(i-1)*COEF_W +: COEF_W]);
            // a tap reaching before the load sees zero history
            if (fill_i >= FILL_W'(i)) begin
                sum_even = sum_even + ACC_W'(prod);
            end
        end
    end

    always_comb begin
        logic signed [PW-1:0] prod;
        sum_odd = '0;
        for (int i = 1; i < NO; i++) begin
            prod = $signed(dly_odd_i[(i-1)*DATA_W +: DATA_W])
                 * $signed(coef_odd_i[(i-1)*COEF_W +: COEF_W]);
            if (fill_i >= FILL_W'(i)) begin
                sum_odd = sum_odd + ACC_W'(prod);
            end
        end
    end

    assign acc_o = base + sum_even + sum_odd;
endmodule

// File: rtl/line_poly_combiner.sv
module line_poly_combiner #(
    parameter int K       = 5,
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int FRAC_W  = 12,
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int OUT_W   = DATA_W + COEF_W - FRAC_W + $clog2(K) + 1
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic                                        load_i,
    input  logic [LEN_W-1:0]                            len_i,
    input  logic [(lpc_pkg::taps_even(K)-1)*COEF_W-1:0] coef_even_i,
    input  logic [(lpc_pkg::taps_odd(K)-1)*COEF_W-1:0]  coef_odd_i,
    input  logic                                        in_valid_i,
    input  logic [DATA_W-1:0]                           ph0_i,
    input  logic [DATA_W-1:0]                           ph1_i,
    output logic                                        out_valid_o,
    output logic [OUT_W-1:0]                            out_o
);
    localparam int NE     = lpc_pkg::taps_even(K);
    localparam int NO     = lpc_pkg::taps_odd(K);
    localparam int MAXD   = NE - 1;
    localparam int AW     = $clog2(MAX_LEN);
    localparam int FILL_W = $clog2(MAXD + 1) + 1;
    localparam int ACC_W  = OUT_W + FRAC_W;

    logic [AW-1:0]     ptr_w;
    logic [LEN_W-1:0]  len_w;
    logic [FILL_W-1:0] fill_w;
    logic              accept;

    assign accept = in_valid_i && !load_i;

    lpc_ctrl #(
        .MAX_LEN(MAX_LEN), .MAXD(MAXD), .AW(AW), .LEN_W(LEN_W), .FILL_W(FILL_W)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_i),
        .len_i     (len_i),
        .in_valid_i(in_valid_i),
        .ptr_o     (ptr_w),
        .len_o     (len_w),
        .fill_o    (fill_w)
    );

    // chained line buffers; stage 0 is the undelayed input
    logic [DATA_W-1:0] even_tap [NE];
    logic [DATA_W-1:0] odd_tap  [NO];
    logic [(NE-1)*DATA_W-1:0] dly_even;
    logic [(NO-1)*DATA_W-1:0] dly_odd;

    assign even_tap[0] = ph0_i;
    assign odd_tap[0]  = ph1_i;

    for (genvar e = 1; e < NE; e++) begin : g_even_line
        lpc_line_buf #(.WIDTH(DATA_W), .DEPTH(MAX_LEN), .AW(AW)) u_buf (
            .clk_i  (clk_i),
            .we_i   (accept),
            .addr_i (ptr_w),
            .wdata_i(even_tap[e-1]),
            .rdata_o(even_tap[e])
        );
        assign dly_even[(e-1)*DATA_W +: DATA_W] = even_tap[e];
    end

    for (genvar o = 1; o < NO; o++) begin : g_odd_line
        lpc_line_buf #(.WIDTH(DATA_W), .DEPTH(MAX_LEN), .AW(AW)) u_buf (
            .clk_i  (clk_i),
            .we_i   (accept),
            .addr_i (ptr_w),
            .wdata_i(odd_tap[o-1]),
            .rdata_o(odd_tap[o])
        );
        assign dly_odd[(o-1)*DATA_W +: DATA_W] = odd_tap[o];
    end

    logic signed [ACC_W-1:0] acc_w;

    lpc_tap_sum #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
        .NE(NE), .NO(NO), .ACC_W(ACC_W), .FILL_W(FILL_W)
    ) u_sum (
        .ph0_i      (ph0_i),
        .ph1_i      (ph1_i),
        .dly_even_i (dly_even),
        .dly_odd_i  (dly_odd),
        .coef_even_i(coef_even_i),
        .coef_odd_i (coef_odd_i),
        .fill_i     (fill_w),
        .acc_o      (acc_w)
    );

    typedef struct packed {
        logic [OUT_W-1:0] out;
        logic             vld;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        logic signed [ACC_W-1:0] shifted;
        shifted = acc_w >>> FRAC_W;
        o_d     = o_q;
        o_d.vld = 1'b0;
        if (accept) begin
            o_d.out = shifted[OUT_W-1:0];
            o_d.vld = (fill_w >= FILL_W'(MAXD));
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid_o = o_q.vld;
    assign out_o       = o_q.out;
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
    parameter int MAX_LEN = 64,
    parameter int AW      = 6,
    parameter int LEN_W   = 7,
    parameter int FILL_W  = 3,
    parameter int OUT_W   = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              load_i,
    input logic              in_valid_i,
    input logic              out_valid_o,
    input logic [OUT_W-1:0]  out_o,
    input logic [AW-1:0]     ptr,
    input logic [LEN_W-1:0]  len,
    input logic [FILL_W-1:0] fill
);
    p_hold_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_valid_i || load_i) |=> $stable(out_o));

    p_valid_needs_sample_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_valid_i || load_i) |=> !out_valid_o);

    p_ptr_in_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, ptr} < (LEN_W + 1)'(len)));

    p_len_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (len != '0) && (len <= LEN_W'(MAX_LEN)));

    p_history_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (fill == '0));
endmodule

bind line_poly_combiner lpc_checker #(
    .MAX_LEN(MAX_LEN), .AW(AW), .LEN_W(LEN_W), .FILL_W(FILL_W), .OUT_W(OUT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .in_valid_i (in_valid_i),
    .out_valid_o(out_valid_o),
    .out_o      (out_o),
    .ptr        (ptr_w),
    .len        (len_w),
    .fill       (fill_w)
);

// File: tb/line_poly_combiner_tb.sv
module line_poly_combiner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int K       = 5;
    localparam int DATA_W  = 16;
    localparam int COEF_W  = 16;
    localparam int FRAC_W  = 12;
    localparam int MAX_LEN = 64;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int OUT_W   = DATA_W + COEF_W - FRAC_W + $clog2(K) + 1;
    localparam int NE      = (K + 1) / 2;
    localparam int NO      = K / 2;

    logic clk = 0;
    logic rst_n = 0;
    logic load = 0;
    logic [LEN_W-1:0] len = '0;
    logic [(NE-1)*COEF_W-1:0] c_even = '0;
    logic [(NO-1)*COEF_W-1:0] c_odd = '0;
    logic vld = 0;
    logic [DATA_W-1:0] a = '0, b = '0;
    logic out_valid;
    logic [OUT_W-1:0] out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_poly_combiner #(
        .K(K), .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .MAX_LEN(MAX_LEN)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .len_i(len),
        .coef_even_i(c_even), .coef_odd_i(c_odd), .in_valid_i(vld),
        .ph0_i(a), .ph1_i(b), .out_valid_o(out_valid), .out_o(out)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference
    longint h_even[$];
    longint h_odd[$];
    int     m_len = MAX_LEN;
    longint exp_out = 0;
    bit     exp_vld = 0;

    function automatic longint ce(input int i);
        return longint'($signed(c_even[(i-1)*COEF_W +: COEF_W]));
    endfunction
    function automatic longint co(input int i);
        return longint'($signed(c_odd[(i-1)*COEF_W +: COEF_W]));
    endfunction

    task automatic compare();
        longint got;
        got = longint'($signed(out));
        n_checks++;
        if (got != exp_out || out_valid != exp_vld) begin
            n_fail++;
            $display("FAIL %s: out=%0d valid=%0b expected out=%0d valid=%0b",
                     tag, got, out_valid, exp_out, exp_vld);
        end
    endtask

    task automatic step(input bit ld, input int ln, input bit v, input int x0, input int x1);
        longint s_acc;
        int     s;
        load = ld;
        len  = LEN_W'(ln);
        vld  = v;
        a    = DATA_W'(x0);
        b    = DATA_W'(x1);
        @(posedge clk);
        if (ld) begin
            m_len = (ln == 0 || ln > MAX_LEN) ? MAX_LEN : ln;
            h_even.delete();
            h_odd.delete();
            exp_vld = 0;
        end else if (v) begin
            h_even.push_back(longint'(x0));
            h_odd.push_back(longint'(x1));
            s = h_even.size() - 1;
            s_acc = (longint'(x0) + longint'(x1)) * (longint'(1) << FRAC_W);
            for (int i = 1; i < NE; i++)
                if (s >= i * m_len) s_acc += ce(i) * h_even[s - i * m_len];
            for (int i = 1; i < NO; i++)
                if (s >= i * m_len) s_acc += co(i) * h_odd[s - i * m_len];
            exp_out = s_acc >>> FRAC_W;
            exp_vld = (s >= (NE - 1) * m_len);
        end else begin
            exp_vld = 0;
        end
        #(CLK_PERIOD / 4);
        compare();
    endtask

    function automatic int rnd();
        return int'($urandom_range(4000)) - 2000;
    endfunction

    task automatic run(input int n, input int idle_pct, input bit use0, input bit use1);
        for (int k = 0; k < n; k++) begin
            bit v;
            v = (int'($urandom_range(99)) >= idle_pct);
            step(0, 0, v, use0 ? rnd() : 0, use1 ? rnd() : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 4);
        tag = "R1";
        compare();               // R1: reset state
        rst_n = 1;
        step(0, 0, 0, 0, 0);     // R1: idle after reset
        // R1: default length MAX_LEN, valid only after two lines
        run(2 * MAX_LEN + 5, 0, 1, 1);

        tag = "R2";              // unit weight, all ratios zero
        c_even = '0; c_odd = '0;
        step(1, 8, 0, 0, 0);
        run(30, 0, 1, 1);

        tag = "R3";              // even chain only
        c_even = {16'sd5120, -16'sd2048};   // tap2 = 1.25, tap1 = -0.5
        c_odd  = '0;
        step(1, 5, 0, 0, 0);
        run(40, 0, 1, 0);

        tag = "R4";              // odd chain only
        c_even = '0;
        c_odd  = 16'sd11264;     // 2.75
        step(1, 6, 0, 0, 0);
        run(30, 0, 0, 1);

        tag = "R5";              // fractional, negative ratios, floor rounding
        c_even = {-16'sd3001, 16'sd777};
        c_odd  = -16'sd12345;
        step(1, 7, 0, 0, 0);
        run(50, 0, 1, 1);

        tag = "R6";              // idle gaps do not advance the delay
        step(1, 4, 0, 0, 0);
        run(80, 40, 1, 1);

        tag = "R7";              // out-of-range lengths clamp to MAX_LEN
        step(1, 0, 1, 1234, -999);
        run(2 * MAX_LEN + 3, 0, 1, 1);
        step(1, 100, 0, 0, 0);
        run(2 * MAX_LEN + 3, 10, 1, 1);
        step(1, 3, 1, 1500, 1500);          // sample in load cycle ignored
        run(20, 0, 1, 1);

        tag = "R8";              // stale buffer content must not leak
        step(1, 10, 0, 0, 0);
        run(25, 0, 1, 1);

        tag = "R9";              // shortest line
        step(1, 1, 0, 0, 0);
        run(12, 0, 1, 1);

        tag = "R10";             // output holds across idle cycles
        step(1, 2, 0, 0, 0);
        run(40, 60, 1, 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule